// File: doc/BRIEF.md
# Keyed External Reset Pulse Generator

This block turns a single-cycle watchdog expiry strobe into a timed reset pulse for an external pin. The pulse length is counted in microsecond ticks. The ticks come from a prescaler that divides the block clock by a parameter. One 32-bit configuration word, written over a simple register bus, holds the pulse length, the active level and the pad drive style.

The active level and the drive style can only be changed by writing one of four key values into the top byte of the configuration word. Any other top-byte value leaves both unchanged. When read back, the two settings appear as plain bits. The duration field is stored on every write, whatever the top byte holds. A stored length value of N gives a pulse of N+1 ticks.

The block presents a pin level and a pin output-enable. In open-drain style the output-enable is raised only while the pin is driven to its active level. In push-pull style the output-enable stays raised at all times.

Top module: `xrst_pulse_top`

## Requirements
- R1: After reset the configuration reads 0x000000FF (length 255, active-low, open-drain), the pin level is high and the output-enable is low.
- R2: Every write stores write-data bits 19:0 as the length field, which reads back on bits 19:0.
- R3: Bits 29:20 of the configuration always read as zero, whatever was written there.
- R4: A write with top byte 0xA5 makes bit 31 read 1 (active-high). A write with top byte 0x5A makes it read 0 (active-low).
- R5: A write with top byte 0xA8 makes bit 30 read 1 (push-pull). A write with top byte 0x8A makes it read 0 (open-drain).
- R6: A write whose top byte is none of the four keys leaves bits 31 and 30 unchanged.
- R7: A trigger while idle starts a pulse in the next cycle. The pulse lasts exactly (N+1)*TICK_CYCLES clock cycles, where N is the stored length at the trigger.
- R8: A trigger during a pulse restarts it, so the pulse then lasts (N+1)*TICK_CYCLES cycles from the cycle after that trigger.
- R9: The length is taken when the trigger occurs. A length write during a pulse does not change that pulse.
- R10: During a pulse the pin level equals bit 31. Outside a pulse it is the inverse of bit 31.
- R11: With bit 30 set the output-enable is always high. With bit 30 clear it is high only during a pulse.
- R12: A length of 0 gives a pulse of exactly one tick (TICK_CYCLES cycles).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Current configuration word |
| trig | input | 1 | Watchdog expiry strobe |
| pulse_out | output | 1 | Pin level |
| pulse_oe | output | 1 | Pin output-enable |

## Verification
The bench builds the block with TICK_CYCLES set to 4 and leaves the reset length at its default of 0xFF. The short tick keeps every prescaler boundary within a few cycles, so one-tick pulses, retriggers partway through a tick and length writes during a pulse can all be compared cycle by cycle. The default length gives a full 1024-cycle pulse, which is short enough to run in full.

// File: rtl/xrst_pkg.sv
package xrst_pkg;
    localparam int DUR_W   = 20;
    localparam int WORD_W  = 32;
    localparam int KEY_LSB = 24;
    localparam int POL_BIT = 31;
    localparam int DRV_BIT = 30;

    localparam logic [7:0] KEY_POL_HIGH = 8'hA5;
    localparam logic [7:0] KEY_POL_LOW  = 8'h5A;
    localparam logic [7:0] KEY_DRV_PP   = 8'hA8;
    localparam logic [7:0] KEY_DRV_OD   = 8'h8A;

    typedef struct packed {
        logic             pol_high;
        logic             push_pull;
        logic [DUR_W-1:0] dur;
    } cfg_t;
endpackage

// File: rtl/xrst_cfg_reg.sv
module xrst_cfg_reg
    import xrst_pkg::*;
#(
    parameter logic [DUR_W-1:0] DUR_RESET = 20'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    output cfg_t              cfg,
    output logic [WORD_W-1:0] rdata
);
    localparam int PAD_W = DRV_BIT - DUR_W;

    cfg_t state_d, state_q;
    logic [7:0] key;
    logic unused_mid;

    assign key        = wdata[WORD_W-1:KEY_LSB];
    assign unused_mid = ^wdata[KEY_LSB-1:DUR_W];

    always_comb begin
        state_d = state_q;
        if (wr) begin
            state_d.dur = wdata[DUR_W-1:0];
            case (key)
                KEY_POL_HIGH: state_d.pol_high  = 1'b1;
                KEY_POL_LOW:  state_d.pol_high  = 1'b0;
                KEY_DRV_PP:   state_d.push_pull = 1'b1;
                KEY_DRV_OD:   state_d.push_pull = 1'b0;
                default:      ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{pol_high: 1'b0, push_pull: 1'b0, dur: DUR_RESET};
        end else begin
            state_q <= state_d;
        end
    end

    assign cfg   = state_q;
    assign rdata = {state_q.pol_high, state_q.push_pull, {PAD_W{1'b0}}, state_q.dur};
endmodule

// File: rtl/xrst_tick_div.sv
module xrst_tick_div #(
    parameter int TICK_CYCLES = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic tick
);
    localparam int CNT_W = $clog2(TICK_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_t;

    div_t state_d, state_q;

    assign tick = run && (state_q.cnt == LAST);

    always_comb begin
        state_d = state_q;
        if (clear || !run || tick) begin
            state_d.cnt = '0;
        end else begin
            state_d.cnt = state_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/xrst_pulse_ctl.sv
module xrst_pulse_ctl
    import xrst_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic [DUR_W-1:0] dur,
    input  logic             tick,
    output logic             active
);
    typedef struct packed {
        logic             active;
        logic [DUR_W-1:0] remain;
    } ctl_t;

    ctl_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (trig) begin
            state_d.active = 1'b1;
            state_d.remain = dur;
        end else if (state_q.active && tick) begin
            if (state_q.remain == '0) begin
                state_d.active = 1'b0;
            end else begin
                state_d.remain = state_q.remain - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign active = state_q.active;
endmodule

// File: rtl/xrst_pad_drv.sv
module xrst_pad_drv (
    input  logic active,
    input  logic pol_high,
    input  logic push_pull,
    output logic level,
    output logic oe
);
    always_comb begin
        level = active ? pol_high : !pol_high;
        oe    = push_pull || active;
    end
endmodule

// File: rtl/xrst_pulse_top.sv
module xrst_pulse_top
    import xrst_pkg::*;
#(
    parameter int                TICK_CYCLES = 50,
    parameter logic [DUR_W-1:0]  DUR_RESET   = 20'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] cfg_rdata,
    input  logic              trig,
    output logic              pulse_out,
    output logic              pulse_oe
);
    cfg_t cfg;
    logic tick;
    logic pulse_active;

    xrst_cfg_reg #(.DUR_RESET(DUR_RESET)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .rdata (cfg_rdata)
    );

    xrst_tick_div #(.TICK_CYCLES(TICK_CYCLES)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (pulse_active),
        .clear (trig),
        .tick  (tick)
    );

    xrst_pulse_ctl u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig   (trig),
        .dur    (cfg.dur),
        .tick   (tick),
        .active (pulse_active)
    );

    xrst_pad_drv u_pad (
        .active    (pulse_active),
        .pol_high  (cfg.pol_high),
        .push_pull (cfg.push_pull),
        .level     (pulse_out),
        .oe        (pulse_oe)
    );
endmodule

// File: rtl/xrst_pulse_chk.sv
module xrst_pulse_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr,
    input logic [31:0] cfg_wdata,
    input logic [31:0] cfg_rdata,
    input logic        trig,
    input logic        pulse_out,
    input logic        pulse_oe
);
    // R3
    mid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[29:20] == 10'd0);

    // R2
    dur_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> cfg_rdata[19:0] == $past(cfg_wdata[19:0]));

    // R4
    pol_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wdata[31:24] == 8'hA5) |=> cfg_rdata[31]);

    // R5
    drv_pp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wdata[31:24] == 8'hA8) |=> cfg_rdata[30]);

    // R6
    key_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr || (cfg_wdata[31:24] != 8'hA5 && cfg_wdata[31:24] != 8'h5A &&
                     cfg_wdata[31:24] != 8'hA8 && cfg_wdata[31:24] != 8'h8A))
        |=> $stable(cfg_rdata[31:30]));

    // R7
    trig_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> pulse_out == cfg_rdata[31]);

    // R11
    pp_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[30] |-> pulse_oe);

    // R11
    od_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rdata[30] |-> (pulse_oe == (pulse_out == cfg_rdata[31])));
endmodule

bind xrst_pulse_top xrst_pulse_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .trig      (trig),
    .pulse_out (pulse_out),
    .pulse_oe  (pulse_oe)
);

// File: tb/xrst_pulse_top_bench.sv
`timescale 1ns/1ps
module xrst_pulse_top_bench;
    localparam int TICKS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        trig = 1'b0;
    logic        pulse_out;
    logic        pulse_oe;

    int compared = 0;
    int mismatched = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    // behavioural reference state
    bit m_pol, m_pp;
    int m_dur;
    int remain;

    always #10 clk = ~clk;

    xrst_pulse_top #(.TICK_CYCLES(TICKS)) u_xrst_pulse_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .trig      (trig),
        .pulse_out (pulse_out),
        .pulse_oe  (pulse_oe)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pol = 0; m_pp = 0; m_dur = 255; remain = 0;
        end else begin
            int dur_then;
            dur_then = m_dur;
            if (cfg_wr) begin
                m_dur = int'(cfg_wdata[19:0]);
                if (cfg_wdata[31:24] == 8'hA5) m_pol = 1;
                else if (cfg_wdata[31:24] == 8'h5A) m_pol = 0;
                else if (cfg_wdata[31:24] == 8'hA8) m_pp = 1;
                else if (cfg_wdata[31:24] == 8'h8A) m_pp = 0;
            end
            if (trig) remain = (dur_then + 1) * TICKS;
            else if (remain > 0) remain--;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            logic [31:0] exp_rd;
            logic exp_lvl, exp_oe;
            exp_rd  = {m_pol, m_pp, 10'd0, m_dur[19:0]};
            exp_lvl = (remain > 0) ? m_pol : !m_pol;
            exp_oe  = m_pp || (remain > 0);
            chk(cur_req, cfg_rdata, exp_rd);
            chk(cur_req, {30'd0, pulse_out, pulse_oe}, {30'd0, exp_lvl, exp_oe});
        end
    end

    task automatic wr_cfg(logic [31:0] data);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = data;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic fire();
        @(negedge clk);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1: reset state
        #1;
        chk("R1", cfg_rdata, 32'h0000_00FF);
        chk("R1", {30'd0, pulse_out, pulse_oe}, 32'd2);

        cur_req = "R2"; wr_cfg(32'h0000_0003); idle(2);
        cur_req = "R3"; wr_cfg(32'h3FF0_0005); idle(2);
        cur_req = "R6"; wr_cfg(32'hFFF0_0002); idle(2);
        cur_req = "R7"; fire(); idle(20);
        cur_req = "R4"; wr_cfg(32'hA500_0002); idle(2);
        cur_req = "R10"; fire(); idle(20);
        cur_req = "R5"; wr_cfg(32'hA800_0001); idle(2);
        cur_req = "R11"; fire(); idle(14);
        cur_req = "R4"; wr_cfg(32'h5A00_0002); idle(2);
        cur_req = "R5"; wr_cfg(32'h8A00_0002); idle(2);
        cur_req = "R8"; fire(); idle(5); fire(); idle(2); fire(); idle(20);
        cur_req = "R9"; fire(); idle(2); wr_cfg(32'h0000_0006); idle(40);
        cur_req = "R12"; wr_cfg(32'h0000_0000); fire(); idle(8);
        cur_req = "R12"; fire(); fire(); idle(8);
        cur_req = "R6"; wr_cfg(32'hA400_0001); wr_cfg(32'h8B00_0001); idle(2);
        cur_req = "R7"; do_reset(); fire(); idle(1040);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule